// File: doc/BRIEF.md
# Self-relocating invocation proxy

The proxy sits on the client side of a request/response bus and forwards each method invocation to a server object. It caches the server's last known address and knows the fixed address of a locator service. The invocation payload is latched at acceptance, so every bus attempt carries exactly the word the client supplied.

A server that does not answer within 16 cycles is treated as moved. The proxy cancels the pending request and sends a locate request to the locator. That request carries the object identifier, which is the module identifier placed above the instance identifier. A successful reply overwrites the cached address, and the latched request is sent once more to the new address. Only one relocation is tried per invocation.

A locator error means the object is not registered. In that case the proxy raises an exception and stops addressing that server for good. A timeout on the replay, or on the locate request itself, also raises an exception for that invocation, but the proxy stays usable.

Top module: `inv_proxy`

## Requirements
- R1: After reset the proxy is ready, drives no bus request, no cancel and no completion, and its cached address equals INIT_ADDR.
- R2: An accepted invocation is driven with `bus_req_o` high to the cached address, carrying the latched payload on `bus_wdata_o`. It is held until `bus_ack_i`. Completion (`inv_done_o` high, `inv_exc_o` low, `inv_rdata_o` equal to `bus_rdata_i`) is signalled in the acknowledge cycle.
- R3: If a request stays unacknowledged for 16 consecutive cycles, `bus_req_o` drops after the 16th cycle and `bus_cancel_o` is high for exactly the next cycle.
- R4: After the first timeout of an invocation, a locate request goes to LOC_ADDR. Its `bus_wdata_o` is {MOD_ID, INST_ID} (module identifier in the upper bits), zero-extended to DATA_W.
- R5: A locate acknowledge loads `bus_rdata_i[ADDR_W-1:0]` into the cached address. The next request replays the same payload to that address.
- R6: Invocations that follow a successful relocation go straight to the new address, with no locate request.
- R7: A locator error ends the invocation with `inv_done_o` and `inv_exc_o` high and makes the proxy dead. While dead, every offered invocation completes with an exception in the same cycle and issues no bus request.
- R8: A timeout of the replay ends the invocation with an exception, without a second locate request. The proxy stays live, and the cached address keeps the locator's reply.
- R9: A timeout of the locate request is cancelled like a call and ends the invocation with an exception. The cached address is left unchanged.
- R10: `bus_cancel_o` is never high in the same cycle as `bus_req_o`. `inv_exc_o` is only high together with `inv_done_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inv_valid_i | input | 1 | Client offers an invocation |
| inv_ready_o | output | 1 | Proxy idle and able to accept |
| inv_data_i | input | DATA_W | Invocation payload |
| inv_done_o | output | 1 | Invocation finished this cycle |
| inv_exc_o | output | 1 | Finished invocation raised an exception |
| inv_rdata_o | output | DATA_W | Server result on success |
| bus_req_o | output | 1 | Bus request pending |
| bus_addr_o | output | ADDR_W | Target address of the request |
| bus_wdata_o | output | DATA_W | Request payload |
| bus_cancel_o | output | 1 | Cancels the request that timed out |
| bus_ack_i | input | 1 | Target answered |
| bus_err_i | input | 1 | Locator reports an unknown object |
| bus_rdata_i | input | DATA_W | Answer data, or the new address from the locator |

## Verification
The checker watches every cycle for three things: a request never stays unanswered beyond the window, a cancel always follows a request that ran out, and address and payload stay stable while a request waits. It also checks that a dead proxy never drives the bus and that an exception never appears without completion.

Only the bench scenarios can show the rest. These cover the address sequence of a relocation and the bit-identical replay. They also cover the cached address surviving a failed or successful attempt into later invocations, and the difference between the three failure paths, where only an unknown object kills the proxy.

// File: rtl/proxy_pkg.sv
package proxy_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CALL,
    ST_CANCEL,
    ST_LOCATE,
    ST_FAIL
  } proxy_st_e;
endpackage

// File: rtl/proxy_timer.sv
module proxy_timer #(
  parameter int TIMEOUT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  localparam int CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || expire_o) cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/proxy_addr_cache.sv
module proxy_addr_cache #(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] INIT_ADDR = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_o <= INIT_ADDR;
    else if (load_i) addr_o <= addr_i;
  end
endmodule

// File: rtl/inv_proxy.sv
module inv_proxy
  import proxy_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 32,
  parameter int                MOD_W     = 8,
  parameter int                INST_W    = 8,
  parameter logic [MOD_W-1:0]  MOD_ID    = 8'h3C,
  parameter logic [INST_W-1:0] INST_ID   = 8'h05,
  parameter logic [ADDR_W-1:0] INIT_ADDR = 16'h0100,
  parameter logic [ADDR_W-1:0] LOC_ADDR  = 16'hFF00,
  parameter int                TIMEOUT   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inv_valid_i,
  output logic              inv_ready_o,
  input  logic [DATA_W-1:0] inv_data_i,
  output logic              inv_done_o,
  output logic              inv_exc_o,
  output logic [DATA_W-1:0] inv_rdata_o,
  output logic              bus_req_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              bus_cancel_o,
  input  logic              bus_ack_i,
  input  logic              bus_err_i,
  input  logic [DATA_W-1:0] bus_rdata_i
);
  localparam int OID_W = MOD_W + INST_W;
  localparam logic [OID_W-1:0] OBJ_ID = {MOD_ID, INST_ID};

  proxy_st_e         st_q;
  logic [DATA_W-1:0] data_q;
  logic              relocated_q;
  logic              go_loc_q;
  logic              fail_dead_q;
  logic              dead_q;
  logic [ADDR_W-1:0] cache_addr;
  logic              in_call, in_loc, run, expire, loc_ok, reject;

  assign in_call = (st_q == ST_CALL);
  assign in_loc  = (st_q == ST_LOCATE);
  assign loc_ok  = in_loc && bus_ack_i;
  // timer runs only while a request waits for its answer
  assign run     = (in_call && !bus_ack_i) || (in_loc && !bus_ack_i && !bus_err_i);
  assign reject  = (st_q == ST_IDLE) && inv_valid_i && dead_q;

  proxy_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .expire_o (expire)
  );

  proxy_addr_cache #(.ADDR_W(ADDR_W), .INIT_ADDR(INIT_ADDR)) u_cache (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (loc_ok),
    .addr_i (bus_rdata_i[ADDR_W-1:0]),
    .addr_o (cache_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      data_q      <= '0;
      relocated_q <= 1'b0;
      go_loc_q    <= 1'b0;
      fail_dead_q <= 1'b0;
      dead_q      <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (inv_valid_i && !dead_q) begin
          data_q      <= inv_data_i;
          relocated_q <= 1'b0;
          st_q        <= ST_CALL;
        end
        ST_CALL: begin
          if (bus_ack_i) st_q <= ST_IDLE;
          else if (expire) begin
            go_loc_q <= !relocated_q;
            st_q     <= ST_CANCEL;
          end
        end
        ST_CANCEL: begin
          fail_dead_q <= 1'b0;
          st_q        <= go_loc_q ? ST_LOCATE : ST_FAIL;
        end
        ST_LOCATE: begin
          if (bus_ack_i) begin
            relocated_q <= 1'b1;
            st_q        <= ST_CALL;
          end else if (bus_err_i) begin
            fail_dead_q <= 1'b1;
            st_q        <= ST_FAIL;
          end else if (expire) begin
            go_loc_q <= 1'b0;
            st_q     <= ST_CANCEL;
          end
        end
        ST_FAIL: begin
          dead_q <= fail_dead_q;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign inv_ready_o  = (st_q == ST_IDLE);
  assign bus_req_o    = in_call || in_loc;
  assign bus_addr_o   = in_loc ? LOC_ADDR : cache_addr;
  assign bus_wdata_o  = in_loc ? DATA_W'(OBJ_ID) : data_q;
  assign bus_cancel_o = (st_q == ST_CANCEL);
  assign inv_done_o   = (in_call && bus_ack_i) || (st_q == ST_FAIL) || reject;
  assign inv_exc_o    = (st_q == ST_FAIL) || reject;
  assign inv_rdata_o  = bus_rdata_i;
endmodule

// File: rtl/proxy_chk.sv
module proxy_chk #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int TIMEOUT = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              inv_ready_o,
  input logic              inv_done_o,
  input logic              inv_exc_o,
  input logic              bus_req_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [DATA_W-1:0] bus_wdata_o,
  input logic              bus_cancel_o,
  input logic              bus_ack_i,
  input logic              bus_err_i,
  input logic              dead_i
);
  localparam int WW = $clog2(TIMEOUT + 1) + 1;
  logic [WW-1:0] wait_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wait_q <= '0;
    else if (bus_req_o && !bus_ack_i && !bus_err_i && wait_q != '1) wait_q <= wait_q + 1'b1;
    else wait_q <= '0;
  end

  AST_WAIT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> (wait_q < WW'(TIMEOUT)));  // R3
  AST_CANCEL_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(bus_req_o) && !$past(bus_ack_i) && !$past(bus_err_i)) |-> bus_cancel_o);  // R3
  AST_CANCEL_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_cancel_o |-> ($past(bus_req_o) && $past(wait_q) == WW'(TIMEOUT - 1)));  // R3
  AST_REQ_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && $past(bus_req_o) && !$past(bus_ack_i) && !$past(bus_err_i))
      |-> ($stable(bus_addr_o) && $stable(bus_wdata_o)));  // R2
  AST_NO_CANCEL_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_cancel_o && bus_req_o));  // R10
  AST_EXC_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_exc_o |-> inv_done_o);  // R10
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_ready_o |-> !bus_req_o);  // R1
  AST_DEAD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dead_i |-> !bus_req_o);  // R7
endmodule

bind inv_proxy proxy_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIMEOUT(TIMEOUT)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .inv_ready_o  (inv_ready_o),
  .inv_done_o   (inv_done_o),
  .inv_exc_o    (inv_exc_o),
  .bus_req_o    (bus_req_o),
  .bus_addr_o   (bus_addr_o),
  .bus_wdata_o  (bus_wdata_o),
  .bus_cancel_o (bus_cancel_o),
  .bus_ack_i    (bus_ack_i),
  .bus_err_i    (bus_err_i),
  .dead_i       (dead_q)
);

// File: tb/sim_inv_proxy.sv
module sim_inv_proxy;
  localparam logic [15:0] INIT = 16'h0100;
  localparam logic [15:0] LOC  = 16'hFF00;
  localparam logic [31:0] OBJ  = 32'h0000_3C05;
  localparam logic [31:0] MASK = 32'h5A5A_0F0F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inv_valid = 1'b0;
  logic [31:0] inv_data = '0;
  logic        inv_ready, inv_done, inv_exc;
  logic [31:0] inv_rdata;
  logic        bus_req, bus_cancel, bus_ack, bus_err;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  always #10 clk = ~clk;

  inv_proxy u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .inv_valid_i(inv_valid), .inv_ready_o(inv_ready), .inv_data_i(inv_data),
    .inv_done_o(inv_done), .inv_exc_o(inv_exc), .inv_rdata_o(inv_rdata),
    .bus_req_o(bus_req), .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata),
    .bus_cancel_o(bus_cancel), .bus_ack_i(bus_ack), .bus_err_i(bus_err),
    .bus_rdata_i(bus_rdata)
  );

  // bus responder: server at srv_addr, locator at LOC
  logic [15:0] srv_addr = INIT;
  int          srv_lat = 0;
  int          loc_mode = 0;  // 0 answer, 1 error, 2 silent
  int          loc_lat = 1;
  logic [15:0] loc_reply = '0;
  int          lat_cnt = 0;

  always_comb begin
    bus_ack = 1'b0; bus_err = 1'b0; bus_rdata = '0;
    if (bus_req) begin
      if (bus_addr == LOC) begin
        if (loc_mode == 0 && lat_cnt >= loc_lat) begin bus_ack = 1'b1; bus_rdata = {16'h0, loc_reply}; end
        else if (loc_mode == 1 && lat_cnt >= loc_lat) bus_err = 1'b1;
      end else if (bus_addr == srv_addr && lat_cnt >= srv_lat) begin
        bus_ack = 1'b1; bus_rdata = bus_wdata ^ MASK;
      end
    end
  end

  always @(posedge clk) begin
    if (bus_req && !bus_ack && !bus_err) lat_cnt <= lat_cnt + 1;
    else lat_cnt <= 0;
  end

  // transaction log
  int          tr_n, cancel_n, ovl_n;
  logic [15:0] tr_addr [8];
  logic [31:0] tr_data [8];
  int          tr_len  [8];
  bit          open_tr;

  initial ovl_n = 0;
  always begin
    @(negedge clk); #2;
    if (bus_req && bus_cancel) ovl_n++;
    if (bus_cancel) cancel_n++;
    if (bus_req) begin
      if (!open_tr) begin
        if (tr_n < 8) begin tr_addr[tr_n] = bus_addr; tr_data[tr_n] = bus_wdata; tr_len[tr_n] = 0; end
        tr_n++;
        open_tr = 1'b1;
      end
      if (tr_n <= 8) tr_len[tr_n-1]++;
      if (bus_ack || bus_err) open_tr = 1'b0;
    end else open_tr = 1'b0;
  end

  int total = 0, bad = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic invoke(input logic [31:0] d, output logic exc, output logic [31:0] res, output int cyc);
    int n = 0;
    bit fin = 0;
    exc = 1'bx; res = 'x; cyc = -1;
    @(negedge clk);
    tr_n = 0; cancel_n = 0; open_tr = 1'b0;
    inv_valid = 1'b1; inv_data = d;
    while (!fin && n < 400) begin
      #2;
      if (inv_done) begin fin = 1; exc = inv_exc; res = inv_rdata; cyc = n; end
      @(posedge clk); #1 inv_valid = 1'b0;
      @(negedge clk); n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic        e;
    logic [31:0] r, d;
    int          c;
    tr_n = 0; cancel_n = 0; open_tr = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check(inv_ready && !bus_req && !bus_cancel && !inv_done, "R1", "reset outputs",
          {inv_ready, bus_req, bus_cancel, inv_done}, 4'b1000);
    @(negedge clk); rst_n = 1'b1;
    #2;
    check(inv_ready && !bus_req && !bus_cancel && !inv_done, "R1", "after release",
          {inv_ready, bus_req, bus_cancel, inv_done}, 4'b1000);

    // R2 latency sweep across the whole window, first target is INIT (R1)
    for (int lat = 0; lat < 16; lat++) begin
      srv_lat = lat;
      d = 32'h1000_0000 + 32'(lat) * 32'h0101_0001;
      invoke(d, e, r, c);
      check(!e && r == (d ^ MASK), "R2", "result", {e, r}, {1'b0, d ^ MASK});
      check(tr_n == 1 && tr_addr[0] == INIT && tr_data[0] == d, "R2", "single call to cache",
            {tr_n[15:0], tr_addr[0], tr_data[0]}, {16'd1, INIT, d});
      check(tr_len[0] == lat + 1 && cancel_n == 0, "R3", "no timeout within window",
            {tr_len[0][15:0], cancel_n[15:0]}, {16'(lat + 1), 16'd0});
    end

    // relocation: server moves, locator answers
    srv_lat = 0; srv_addr = 16'h0230; loc_mode = 0; loc_reply = 16'h0230; loc_lat = 2;
    d = 32'hCAFE_0001;
    invoke(d, e, r, c);
    check(tr_n == 3 && tr_len[0] == 16 && cancel_n == 1, "R3", "timeout then cancel",
          {tr_n[15:0], tr_len[0][15:0], cancel_n[15:0]}, {16'd3, 16'd16, 16'd1});
    check(tr_addr[1] == LOC && tr_data[1] == OBJ, "R4", "locate request",
          {tr_addr[1], tr_data[1]}, {LOC, OBJ});
    check(tr_addr[2] == 16'h0230 && tr_data[2] == d, "R5", "replay to new address",
          {tr_addr[2], tr_data[2]}, {16'h0230, d});
    check(!e && r == (d ^ MASK), "R5", "replay result", {e, r}, {1'b0, d ^ MASK});

    d = 32'hCAFE_0002;
    invoke(d, e, r, c);
    check(tr_n == 1 && tr_addr[0] == 16'h0230 && !e && r == (d ^ MASK), "R6", "direct to new address",
          {tr_n[15:0], tr_addr[0], r}, {16'd1, 16'h0230, d ^ MASK});

    // replay also times out
    srv_addr = 16'h0470; loc_reply = 16'h0BAD;
    d = 32'hCAFE_0003;
    invoke(d, e, r, c);
    check(e && tr_n == 3 && tr_addr[2] == 16'h0BAD && tr_len[2] == 16 && cancel_n == 2, "R8",
          "second timeout raises exception", {e, tr_n[15:0], tr_addr[2], cancel_n[15:0]},
          {1'b1, 16'd3, 16'h0BAD, 16'd2});
    loc_reply = 16'h0470;
    d = 32'hCAFE_0004;
    invoke(d, e, r, c);
    check(!e && tr_n == 3 && tr_addr[0] == 16'h0BAD && tr_addr[2] == 16'h0470, "R8",
          "still live, cache kept reply", {e, tr_n[15:0], tr_addr[0], tr_addr[2]},
          {1'b0, 16'd3, 16'h0BAD, 16'h0470});

    // locator silent
    srv_addr = 16'h0590; loc_mode = 2;
    d = 32'hCAFE_0005;
    invoke(d, e, r, c);
    check(e && tr_n == 2 && tr_addr[1] == LOC && tr_len[1] == 16 && cancel_n == 2, "R9",
          "locate timeout", {e, tr_n[15:0], tr_len[1][15:0], cancel_n[15:0]},
          {1'b1, 16'd2, 16'd16, 16'd2});
    loc_mode = 0; loc_reply = 16'h0590;
    d = 32'hCAFE_0006;
    invoke(d, e, r, c);
    check(!e && tr_n == 3 && tr_addr[0] == 16'h0470 && tr_addr[2] == 16'h0590, "R9",
          "cache unchanged by failed locate", {e, tr_n[15:0], tr_addr[0], tr_addr[2]},
          {1'b0, 16'd3, 16'h0470, 16'h0590});

    // object unknown
    srv_addr = 16'h0777; loc_mode = 1;
    d = 32'hCAFE_0007;
    invoke(d, e, r, c);
    check(e && tr_n == 2 && tr_addr[1] == LOC, "R7", "locator error exception",
          {e, tr_n[15:0], tr_addr[1]}, {1'b1, 16'd2, LOC});
    for (int k = 0; k < 3; k++) begin
      d = 32'hDEAD_0000 + 32'(k);
      invoke(d, e, r, c);
      check(e && c == 0 && tr_n == 0, "R7", "dead proxy rejects at once",
            {e, c[15:0], tr_n[15:0]}, {1'b1, 16'd0, 16'd0});
    end
    #2;
    check(inv_ready && !bus_req, "R7", "dead proxy quiet", {inv_ready, bus_req}, 2'b10);
    check(ovl_n == 0, "R10", "cancel never with request", 64'(ovl_n), 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule